// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Sequencer

This block decides, at each instruction boundary, whether the processor core should enter an interrupt. It watches two request sources. One is an asynchronous non-maskable line, which is caught on its rising edge. The other is a level-sensitive maskable line, which is gated by the interrupt-enable flag. When both are waiting, the non-maskable request wins and yields a fixed vector type of 2 at once.

A maskable request starts a locked pair of acknowledge bus cycles. The bus side reports the T2 phase and the end of each cycle. The type byte is read at the end of the second cycle, and the block turns it into a vector-table address equal to the type times four. Any interrupt that is taken also produces a pulse that clears the enable flag. From the start of the pair until its last cycle completes, a hold-inhibit output keeps other bus masters off the bus.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0.
- R2: A non-maskable level that stays high through three rising clock edges becomes pending. At the next instruction-boundary strobe, whatever the enable flag holds, `vec_valid` is 1 for exactly one cycle, starting on the cycle after the strobe, with `vec_addr` = 8 (type 2 times four). No acknowledge cycle is run.
- R3: A non-maskable pulse that is high at only one rising edge is ignored: a later boundary strobe produces no vector and no enable-clear pulse.
- R4: If a non-maskable request is pending and the maskable request also qualifies at the same boundary, the non-maskable one is served. The maskable one is then served at a later boundary.
- R5: A maskable request is taken only when `irq_level` was high at the clock edge before the boundary edge and `ie_flag` is 1 at the boundary edge. Otherwise the strobe has no effect. The level present during the strobe cycle itself does not count.
- R6: Each taken interrupt, of either kind, produces a one-cycle `ie_clear` pulse on the cycle after the boundary strobe.
- R7: A maskable take runs two acknowledge cycles. `ack_active` is 1 throughout. `ack_phase` is 0 for the first cycle and 1 for the second, and an `ack_end` pulse moves from one cycle to the next.
- R8: `lock` rises on the cycle after `ack_t2` in the first acknowledge cycle and falls on the cycle after `ack_t2` in the second.
- R9: `hold_inhibit` is 1 from the cycle after a maskable take until the cycle after the second `ack_end`, so it covers every cycle in which `lock` is 1.
- R10: On the cycle after the second `ack_end`, `vec_valid` is 1 for one cycle and `vec_addr` is the 8-bit `ack_data` shifted left by two and zero-extended to 20 bits.
- R11: Boundary strobes during an acknowledge pair are ignored. A non-maskable edge that arrives during the pair stays pending and is served at the first boundary after the pair ends.
- R12: A non-maskable level that stays high after it has been serviced does not trigger again. A new rising edge after servicing has started produces another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_async | input | 1 | Asynchronous non-maskable request |
| irq_level | input | 1 | Level-sensitive maskable request |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| ie_flag | input | 1 | Current interrupt-enable flag |
| ack_t2 | input | 1 | Bus side: current acknowledge cycle is in T2 |
| ack_end | input | 1 | Bus side: current acknowledge cycle completes |
| ack_data | input | 8 | Type byte, valid with the second `ack_end` |
| ie_clear | output | 1 | One-cycle pulse that clears the enable flag |
| ack_active | output | 1 | Acknowledge cycles requested |
| ack_phase | output | 1 | 0 = first acknowledge cycle, 1 = second |
| lock | output | 1 | Bus lock across the acknowledge pair |
| hold_inhibit | output | 1 | Other masters' hold requests must wait |
| vec_valid | output | 1 | One-cycle strobe for `vec_addr` |
| vec_addr | output | 20 | Vector-table address |

## Verification
Every result is registered, so each one appears exactly one cycle after the edge that caused it. The enable-clear pulse, the start of `hold_inhibit` and the non-maskable vector follow the boundary edge. Each `lock` change follows its `ack_t2` edge, and the maskable vector follows the second `ack_end`. A non-maskable level needs three edges before it counts as pending, so the bench waits longer than that before it strobes a boundary. The bench drives and samples on the falling edge, which means every check reads the value registered at the preceding rising edge. The maskable path is swept over all 256 type bytes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int TYPE_W = 8;
  localparam int VEC_W  = 20;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ACK_A = 2'd1,
    SQ_ACK_B = 2'd2
  } seq_state_e;

  // Vector-table entries are four bytes apart: address = type * 4.
  function automatic logic [VEC_W-1:0] table_addr(input logic [TYPE_W-1:0] t);
    logic [VEC_W-1:0] a;
    a = '0;
    a[TYPE_W+1:2] = t;
    return a;
  endfunction
endpackage

// File: rtl/irq_nmi_catch.sv
module irq_nmi_catch #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_async,
  input  logic take,
  output logic pending,
  output logic edge_seen
);
  localparam int RUN_W = $clog2(MIN_HIGH + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level;
  logic [RUN_W-1:0]       run_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= nmi_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_async};
      end
    end
  endgenerate

  assign level = sync_q[SYNC_STAGES-1];

  // Count how long the synchronised level has been high; qualify once per high period.
  assign edge_seen = level && (run_q == RUN_W'(MIN_HIGH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (!level)                          run_q <= '0;
      else if (run_q != RUN_W'(MIN_HIGH))  run_q <= run_q + 1'b1;
      pending <= (pending && !take) || edge_seen;
    end
  end

  a_r12_one_edge_per_level: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !edge_seen);
  a_r2_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> pending);
  a_r3_pending_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(edge_seen));
endmodule

// File: rtl/irq_take_arb.sv
module irq_take_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_level,
  input  logic boundary,
  input  logic busy,
  input  logic nmi_pending,
  input  logic ie_flag,
  output logic take_nmi,
  output logic take_irq
);
  logic irq_q;
  logic window;

  // Maskable level is sampled every clock; the boundary uses the previous sample.
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_level;
  end

  assign window   = boundary && !busy;
  assign take_nmi = window && nmi_pending;
  assign take_irq = window && !nmi_pending && irq_q && ie_flag;

  a_r5_prior_level: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(irq_level));
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_seq_pkg::*;
#(
  parameter logic [TYPE_W-1:0] NMI_TYPE = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_irq,
  input  logic              take_nmi,
  input  logic              ack_t2,
  input  logic              ack_end,
  input  logic [TYPE_W-1:0] ack_data,
  output logic              busy,
  output logic              ack_phase,
  output logic              lock,
  output logic              ie_clear,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_addr
);
  seq_state_e state;

  assign busy      = (state != SQ_IDLE);
  assign ack_phase = (state == SQ_ACK_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      lock      <= 1'b0;
      ie_clear  <= 1'b0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      ie_clear  <= take_irq || take_nmi;
      vec_valid <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (take_irq) begin
            state <= SQ_ACK_A;
          end else if (take_nmi) begin
            vec_valid <= 1'b1;
            vec_addr  <= table_addr(NMI_TYPE);
          end
        end
        SQ_ACK_A: begin
          if (ack_t2)  lock  <= 1'b1;
          if (ack_end) state <= SQ_ACK_B;
        end
        SQ_ACK_B: begin
          if (ack_t2) lock <= 1'b0;
          if (ack_end) begin
            state     <= SQ_IDLE;
            lock      <= 1'b0;
            vec_valid <= 1'b1;
            vec_addr  <= table_addr(ack_data);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clear |=> !ie_clear);
  a_r10_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  a_r8_lock_inside_pair: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> busy);
  a_r8_lock_falls_second: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(ack_phase));
  a_r11_no_take_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(take_irq || take_nmi));
  a_r2_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_nmi) |-> (vec_valid && vec_addr == table_addr(NMI_TYPE)));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_seq_pkg::*;
#(
  parameter int                SYNC_STAGES  = 2,
  parameter int                NMI_MIN_HIGH = 2,
  parameter logic [TYPE_W-1:0] NMI_TYPE     = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_async,
  input  logic              irq_level,
  input  logic              boundary,
  input  logic              ie_flag,
  input  logic              ack_t2,
  input  logic              ack_end,
  input  logic [TYPE_W-1:0] ack_data,
  output logic              ie_clear,
  output logic              ack_active,
  output logic              ack_phase,
  output logic              lock,
  output logic              hold_inhibit,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_addr
);
  logic nmi_pending;
  logic nmi_edge;
  logic take_nmi;
  logic take_irq;
  logic busy;

  irq_nmi_catch #(.SYNC_STAGES(SYNC_STAGES), .MIN_HIGH(NMI_MIN_HIGH)) u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_async (nmi_async),
    .take      (take_nmi),
    .pending   (nmi_pending),
    .edge_seen (nmi_edge)
  );

  irq_take_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_level   (irq_level),
    .boundary    (boundary),
    .busy        (busy),
    .nmi_pending (nmi_pending),
    .ie_flag     (ie_flag),
    .take_nmi    (take_nmi),
    .take_irq    (take_irq)
  );

  irq_ack_ctrl #(.NMI_TYPE(NMI_TYPE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_irq  (take_irq),
    .take_nmi  (take_nmi),
    .ack_t2    (ack_t2),
    .ack_end   (ack_end),
    .ack_data  (ack_data),
    .busy      (busy),
    .ack_phase (ack_phase),
    .lock      (lock),
    .ie_clear  (ie_clear),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
  );

  assign ack_active   = busy;
  assign hold_inhibit = busy;

  a_r5_enable_required: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_inhibit) |-> $past(ie_flag && boundary));
  a_r9_inhibit_covers_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> hold_inhibit);
  a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !busy && nmi_pending) |=> !hold_inhibit);
  a_r12_edge_from_catch: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |-> $past(nmi_async, 2));
endmodule

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_async = 1'b0;
  logic        irq_level = 1'b0;
  logic        boundary = 1'b0;
  logic        ie_flag = 1'b0;
  logic        ack_t2 = 1'b0;
  logic        ack_end = 1'b0;
  logic [7:0]  ack_data = 8'h00;
  logic        ie_clear, ack_active, ack_phase, lock, hold_inhibit, vec_valid;
  logic [19:0] vec_addr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ack_seq i_irq_ack_seq (
    .clk(clk), .rst_n(rst_n), .nmi_async(nmi_async), .irq_level(irq_level),
    .boundary(boundary), .ie_flag(ie_flag), .ack_t2(ack_t2), .ack_end(ack_end),
    .ack_data(ack_data), .ie_clear(ie_clear), .ack_active(ack_active),
    .ack_phase(ack_phase), .lock(lock), .hold_inhibit(hold_inhibit),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int vec_of(input int t);
    return t * 4;
  endfunction

  // Entered on the falling edge right after the take edge.
  task automatic finish_ack(input logic [7:0] t, input bit poke);
    check("R6 clear pulse", ie_clear, 1);
    check("R9 inhibit start", hold_inhibit, 1);
    check("R7 first phase", {ack_active, ack_phase}, 2);
    check("R8 lock before T2", lock, 0);
    ie_flag = 1'b0;
    ack_t2 = 1'b1; boundary = poke;
    tick();
    ack_t2 = 1'b0;
    check("R8 lock rise", lock, 1);
    check("R6 clear single", ie_clear, 0);
    check("R11 still first", {ack_active, ack_phase}, 2);
    ack_end = 1'b1;
    tick();
    ack_end = 1'b0; boundary = 1'b0;
    check("R7 second phase", {ack_active, ack_phase}, 3);
    check("R8 lock held", lock, 1);
    check("R11 no retake", ie_clear, 0);
    ack_t2 = 1'b1;
    tick();
    ack_t2 = 1'b0;
    check("R8 lock fall", lock, 0);
    check("R9 inhibit held", hold_inhibit, 1);
    ack_end = 1'b1; ack_data = t;
    tick();
    ack_end = 1'b0;
    check("R10 vec valid", vec_valid, 1);
    check("R10 vec addr", int'(vec_addr), vec_of(int'(t)));
    check("R9 inhibit end", hold_inhibit, 0);
    check("R7 pair done", ack_active, 0);
    tick();
    check("R10 vec one cycle", vec_valid, 0);
    ie_flag = 1'b1;
  endtask

  task automatic strobe();
    boundary = 1'b1;
    tick();
    boundary = 1'b0;
  endtask

  task automatic expect_nmi(input string req);
    check({req, " nmi vec valid"}, vec_valid, 1);
    check({req, " nmi vec addr"}, int'(vec_addr), 8);
    check({req, " nmi no ack"}, hold_inhibit, 0);
    check({req, " nmi clear"}, ie_clear, 1);
    tick();
    check({req, " nmi vec one cycle"}, vec_valid, 0);
  endtask

  task automatic expect_nothing(input string req);
    check({req, " no vec"}, vec_valid, 0);
    check({req, " no clear"}, ie_clear, 0);
    check({req, " no ack"}, hold_inhibit, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 reset outputs", {ie_clear, ack_active, ack_phase, lock, hold_inhibit, vec_valid}, 0);
    check("R1 reset addr", int'(vec_addr), 0);
    rst_n = 1'b1;
    tick();
    check("R1 after reset", {ie_clear, ack_active, lock, vec_valid}, 0);

    // R10 sweep of every type byte through the maskable path
    irq_level = 1'b1; ie_flag = 1'b1;
    tick();
    for (int t = 0; t < 256; t++) begin
      strobe();
      finish_ack(8'(t), 1'b0);
    end

    // R5 masked: enable flag low
    ie_flag = 1'b0;
    strobe();
    expect_nothing("R5 masked");
    tick();
    check("R5 masked later", hold_inhibit, 0);

    // R5 level rising in the strobe cycle is too late
    ie_flag = 1'b1; irq_level = 1'b0;
    repeat (2) tick();
    irq_level = 1'b1; boundary = 1'b1;
    tick();
    boundary = 1'b0;
    expect_nothing("R5 late level");
    // R5 level high the clock before, low during strobe: taken
    irq_level = 1'b0; boundary = 1'b1;
    tick();
    boundary = 1'b0;
    check("R5 prior level taken", hold_inhibit, 1);
    finish_ack(8'hA5, 1'b0);

    // R3 one-clock non-maskable pulse ignored
    nmi_async = 1'b1;
    tick();
    nmi_async = 1'b0;
    repeat (6) tick();
    strobe();
    expect_nothing("R3 short pulse");

    // R2 long pulse served even with enable low
    ie_flag = 1'b0;
    nmi_async = 1'b1;
    repeat (3) tick();
    nmi_async = 1'b0;
    repeat (4) tick();
    strobe();
    expect_nmi("R2");

    // R4 priority: both qualify at the same boundary
    ie_flag = 1'b1; irq_level = 1'b1;
    nmi_async = 1'b1;
    repeat (4) tick();
    nmi_async = 1'b0;
    repeat (4) tick();
    strobe();
    expect_nmi("R4");
    strobe();
    check("R4 mask later", hold_inhibit, 1);
    finish_ack(8'h5A, 1'b0);

    // R11 NMI edge during an acknowledge pair, boundaries poked inside it
    nmi_async = 1'b1;
    strobe();
    finish_ack(8'h3C, 1'b1);
    irq_level = 1'b0;
    tick();
    strobe();
    expect_nmi("R11");

    // R12 level still high: no retrigger
    repeat (3) tick();
    strobe();
    expect_nothing("R12 held level");
    // R12 fresh edge triggers again
    nmi_async = 1'b0;
    repeat (4) tick();
    nmi_async = 1'b1;
    repeat (4) tick();
    nmi_async = 1'b0;
    repeat (3) tick();
    strobe();
    expect_nmi("R12 new edge");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule